// File: doc/BRIEF.md
# DMA Channel Control Register with Device Enable Signalling

This block is the 32-bit control and status register of a DMA channel that serves a disk-style storage controller. Software writes it through a simple register port and reads it back at any time. Some bits can be written. Others are status bits that only the hardware may change. A fixed version code is merged into the stored value on every update.

Two outputs go to the attached controller. `dev_reset` is a one-cycle pulse that follows any register write with the reset bit set. `dev_dma_en` is a registered level that follows the DMA enable bit, so the attached controller does not start a transfer before the channel allows it. The level changes only when a write actually flips the stored enable bit.

Two small state machines drive the outputs:
- The enable tracker has states `EN_OFF` and `EN_ON`. Transition *arm* (`EN_OFF`→`EN_ON`) is taken on a write with bit 9 set while the stored bit 9 is 0. Transition *disarm* (`EN_ON`→`EN_OFF`) is taken on a write with bit 9 clear while the stored bit 9 is 1.
- The reset pulser has states `RP_IDLE` and `RP_PULSE`. Transition *fire* (`RP_IDLE`→`RP_PULSE`, or `RP_PULSE`→`RP_PULSE`) is taken on a write with bit 7 set. Transition *expire* (`RP_PULSE`→`RP_IDLE`) is taken otherwise.

Top module: `dma_csr_ctrl`

## Requirements
- R1: After reset, `rd_data` equals the `VERSION` parameter, and both `dev_reset` and `dev_dma_en` are 0.
- R2: A write (`wr_en`=1) stores every bit outside `RO_MASK` as written, except as R3 and R4 modify. The new value shows on `rd_data` from the cycle after the write. This covers interrupt enable (bit 4), the write-to-memory direction (bit 8) and the DMA enable (bit 9).
- R3: When the written value has the reset bit (bit 7) clear and the drain bit (bit 6) set, bit 6 is stored as 0. When bit 7 is set, bit 6 is stored as written.
- R4: A write of all zeros stores the drain bit (bit 6) as 1.
- R5: A write with bit 7 set drives `dev_reset` high for exactly the cycle after the write. Without a further such write, it is low in the cycle after that.
- R6: `dev_dma_en` rises in the cycle after a write that sets bit 9 while the stored bit 9 is 0. It falls in the cycle after a write that clears bit 9 while the stored bit 9 is 1. Otherwise it holds, and it always equals `rd_data[9]`.
- R7: Bits inside `RO_MASK` keep their value on register writes. With the default mask, these are interrupt pending (bit 0), address loaded (bit 26) and version bits 31:28. They change only on `status_we`, which loads them from `status_data`. If `status_we` and `wr_en` occur in the same cycle, the read-only bits come from `status_data` and the other bits come from the write.
- R8: Every bit set in `VERSION` reads as 1 at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| status_we | input | 1 | Hardware strobe for loading the read-only bits |
| status_data | input | 32 | Source of the read-only bits (only bits inside `RO_MASK` are used) |
| rd_data | output | 32 | Stored register value |
| dev_reset | output | 1 | One-cycle reset pulse to the attached controller |
| dev_dma_en | output | 1 | DMA enable level to the attached controller |

## Verification
A wrong enable-tracker state shows directly on `dev_dma_en`. It also breaks the agreement with `rd_data[9]` in the very cycle after the faulty write. A stuck or doubled reset pulser shows on `dev_reset` one or two cycles after a write. A faulty write filter or merge shows on `rd_data` in the cycle after the write, as a wrong drain bit, a changed read-only bit or a missing version bit. The bench sweeps all 256 combinations of eight significant bits, including the read-only bits and each special-rule bit. It checks every output one and two cycles after each write.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
    localparam int CSR_W           = 32;
    localparam int BIT_IRQ_PEND    = 0;
    localparam int BIT_IRQ_EN      = 4;
    localparam int BIT_DRAIN       = 6;
    localparam int BIT_RESET       = 7;
    localparam int BIT_TO_MEM      = 8;
    localparam int BIT_DMA_EN      = 9;
    localparam int BIT_ADDR_LOADED = 26;

    typedef enum logic { EN_OFF, EN_ON } en_state_t;
    typedef enum logic { RP_IDLE, RP_PULSE } rp_state_t;

    typedef struct packed {
        logic             valid;
        logic             reset_req;
        logic [CSR_W-1:0] value;
    } wr_cmd_t;
endpackage

// File: rtl/csr_write_filter.sv
module csr_write_filter
    import dma_csr_pkg::*;
(
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    output wr_cmd_t          cmd
);
    localparam logic [CSR_W-1:0] DRAIN_M = CSR_W'(1) << BIT_DRAIN;

    // Reset wins; otherwise drain is dropped; an all-zero word becomes drain.
    always_comb begin
        cmd.valid     = wr_en;
        cmd.reset_req = wr_data[BIT_RESET];
        if (wr_data[BIT_RESET])
            cmd.value = wr_data;
        else if (wr_data[BIT_DRAIN])
            cmd.value = wr_data & ~DRAIN_M;
        else if (wr_data == '0)
            cmd.value = DRAIN_M;
        else
            cmd.value = wr_data;
    end
endmodule

// File: rtl/csr_store.sv
module csr_store
    import dma_csr_pkg::*;
#(
    parameter logic [31:0] RO_MASK = 32'hF400_0001,
    parameter logic [31:0] VERSION = 32'hA000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_cmd_t          cmd,
    input  logic             status_we,
    input  logic [CSR_W-1:0] status_data,
    output logic [CSR_W-1:0] stored
);
    logic [CSR_W-1:0] nxt;

    always_comb begin
        nxt = stored;
        if (cmd.valid)
            nxt = (nxt & RO_MASK) | (cmd.value & ~RO_MASK);
        if (status_we)
            nxt = (nxt & ~RO_MASK) | (status_data & RO_MASK);
        nxt = nxt | VERSION;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stored <= VERSION;
        else        stored <= nxt;
    end

    assert_version_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stored & VERSION) == VERSION);

    assert_ro_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !status_we |=> ((stored & RO_MASK) == ($past(stored) & RO_MASK)));

    assert_drain_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.valid && !RO_MASK[BIT_DRAIN] && !cmd.reset_req && $past(1'b1) &&
         cmd.value[BIT_DRAIN] == 1'b0 && !(cmd.value == (CSR_W'(1) << BIT_DRAIN)))
        |=> !stored[BIT_DRAIN]);
endmodule

// File: rtl/dma_en_fsm.sv
module dma_en_fsm
    import dma_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic wr_en_bit,
    input  logic stored_en,
    output logic dev_dma_en
);
    en_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= EN_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            EN_OFF: if (wr_valid && wr_en_bit && !stored_en)  state_nxt = EN_ON;   // arm
            EN_ON:  if (wr_valid && !wr_en_bit && stored_en)  state_nxt = EN_OFF;  // disarm
        endcase
    end

    always_comb dev_dma_en = (state == EN_ON);

    assert_en_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_en_bit && !dev_dma_en) |=> dev_dma_en);
    assert_en_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_en_bit && dev_dma_en) |=> !dev_dma_en);
endmodule

// File: rtl/reset_pulse_fsm.sv
module reset_pulse_fsm
    import dma_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic dev_reset
);
    rp_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RP_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RP_IDLE:  if (fire) state_nxt = RP_PULSE;          // fire
            RP_PULSE: state_nxt = fire ? RP_PULSE : RP_IDLE;   // fire / expire
        endcase
    end

    always_comb dev_reset = (state == RP_PULSE);

    assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> dev_reset);
    assert_pulse_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !dev_reset);
endmodule

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
    import dma_csr_pkg::*;
#(
    parameter logic [31:0] RO_MASK = 32'hF400_0001,
    parameter logic [31:0] VERSION = 32'hA000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        status_we,
    input  logic [31:0] status_data,
    output logic [31:0] rd_data,
    output logic        dev_reset,
    output logic        dev_dma_en
);
    wr_cmd_t          cmd;
    logic [CSR_W-1:0] stored;

    csr_write_filter u_filter (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    csr_store #(.RO_MASK(RO_MASK), .VERSION(VERSION)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .status_we   (status_we),
        .status_data (status_data),
        .stored      (stored)
    );

    dma_en_fsm u_en (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (cmd.valid),
        .wr_en_bit  (cmd.value[BIT_DMA_EN]),
        .stored_en  (stored[BIT_DMA_EN]),
        .dev_dma_en (dev_dma_en)
    );

    reset_pulse_fsm u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (cmd.valid && cmd.reset_req),
        .dev_reset (dev_reset)
    );

    assign rd_data = stored;

    assert_en_tracks_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dev_dma_en == rd_data[BIT_DMA_EN]);
    assert_pulse_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |-> $past(wr_en && wr_data[BIT_RESET]));
endmodule

// File: tb/dma_csr_ctrl_tb.sv
module dma_csr_ctrl_tb;
    localparam logic [31:0] RO  = 32'hF400_0001;
    localparam logic [31:0] VER = 32'hA000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        status_we = 1'b0;
    logic [31:0] status_data = '0;
    logic [31:0] rd_data;
    logic        dev_reset, dev_dma_en;

    always #4 clk = ~clk;

    dma_csr_ctrl #(.RO_MASK(RO), .VERSION(VER)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .status_we(status_we), .status_data(status_data),
        .rd_data(rd_data), .dev_reset(dev_reset), .dev_dma_en(dev_dma_en)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_reg;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] filt(input logic [31:0] v);
        if (v[7])      return v;
        else if (v[6]) return v & ~32'h40;
        else if (v == 0) return 32'h40;
        else           return v;
    endfunction

    task automatic do_write(input logic [31:0] v);
        logic [31:0] nv;
        logic        old_en;
        string       tag;
        nv = filt(v);
        old_en = exp_reg[9];
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        exp_reg = (exp_reg & RO) | (nv & ~RO) | VER;
        if (v == 0)             tag = "R4 zero write sets drain";
        else if (v[6] && !v[7]) tag = "R3 drain dropped";
        else                    tag = "R2 readback";
        chk(tag, rd_data, exp_reg);
        chk("R7 read-only bits held", rd_data & RO, exp_reg & RO);
        chk("R8 version present", rd_data & VER, VER);
        chk(old_en != nv[9] ? "R6 enable edge" : "R6 enable hold", {31'b0, dev_dma_en}, {31'b0, nv[9]});
        chk("R5 pulse after write", {31'b0, dev_reset}, {31'b0, v[7]});
        @(negedge clk);
        chk("R5 pulse one cycle", {31'b0, dev_reset}, 32'b0);
    endtask

    task automatic do_status(input logic [31:0] s, input logic with_wr, input logic [31:0] v);
        @(negedge clk);
        status_we = 1'b1; status_data = s;
        wr_en = with_wr; wr_data = v;
        @(negedge clk);
        status_we = 1'b0; wr_en = 1'b0; wr_data = '0;
        if (with_wr) exp_reg = (exp_reg & RO) | (filt(v) & ~RO) | VER;
        exp_reg = (exp_reg & ~RO) | (s & RO) | VER;
        chk("R7 status load", rd_data, exp_reg);
        chk("R6 enable matches register", {31'b0, dev_dma_en}, {31'b0, exp_reg[9]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        exp_reg = VER;
        repeat (3) @(negedge clk);
        chk("R1 reset value", rd_data, VER);
        chk("R1 reset pulse low", {31'b0, dev_reset}, 32'b0);
        chk("R1 enable low", {31'b0, dev_dma_en}, 32'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 value after release", rd_data, VER);

        for (int i = 0; i < 256; i++) begin
            logic [31:0] v;
            v = '0;
            v[0] = i[0]; v[4] = i[1]; v[6] = i[2]; v[7] = i[3];
            v[8] = i[4]; v[9] = i[5]; v[26] = i[6]; v[31] = i[7];
            if (i == 128) do_status(32'h0400_0001, 1'b0, '0);
            do_write(v);
        end

        do_write(32'h0000_0000);
        do_write(32'h0FFF_FFFF);
        do_write(32'h0000_0200);
        do_status(32'hFFFF_FFFF, 1'b1, 32'h0000_0110);
        do_write(32'h0000_0000);
        do_status(32'h0000_0000, 1'b1, 32'h0000_0240);
        do_write(32'h5555_5555);
        do_write(32'h0000_0080);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule